// File: doc/BRIEF.md
# Dual-Event Performance Counter Unit

This block sits beside a processor core and counts micro-architectural events for profiling. Sixteen single-cycle event lines come into it. Each of two 32-bit counters picks one of these lines through a 4-bit selector held in a shared control word. A counter advances only while the core's current privilege level is one that the control word enables. Software reaches the unit through a small register port with two registers: the control word, and a 64-bit count register that holds both counters side by side. A single write to the count register loads both counters together.

For sampling, software preloads a counter with 0x80000000 minus the wanted period. Once that many qualifying events have arrived, bit 31 of the counter turns on. If the shared interrupt enable is set, a level interrupt is then driven to the core's interrupt line 6. It stays high until software reloads the counters or clears the enable. A handler usually writes zero to the control word, reads the counts, reloads the counter that overflowed and restores the control word.

Top module: `dual_event_counter`

## Requirements
- R1: After a synchronous reset, the control word and both counters are zero and `irq` is low. A read then returns zero.
- R2: A control write (`wr_sel`=0) stores `wr_data[12:0]`. A read of the control word returns those bits with all higher bits at zero. Read data shows up on `rd_data` in the cycle after `rd_en` and holds until the next read.
- R3: A count write (`wr_sel`=1) loads counter 1 from `wr_data[31:0]` and counter 2 from `wr_data[63:32]` in the same cycle. A count read returns counter 2 in bits 63:32 and counter 1 in bits 31:0.
- R4: Counter 1 counts `events[ctl[8:5]]` and counter 2 counts `events[ctl[12:9]]`. Each counter adds exactly one in every cycle where its selected line is high and the mode gate is open. Lines that are not selected have no effect.
- R5: The active mode is exception level when `priv_exl`=1. Otherwise `priv_lvl` gives the mode: 0 kernel, 1 supervisor, 2 user, 3 none. The gate is open when the control bit for the active mode is set: bit 0 exception level, bit 1 kernel, bit 2 supervisor, bit 3 user. Level 3 never counts.
- R6: A control write takes effect from the next cycle. While the control word is zero, both counters keep their values.
- R7: If a count write and a qualifying event fall in the same cycle, the written value is loaded and no increment is added.
- R8: A count read in a cycle where the counters increment returns the values from before that increment.
- R9: `irq` is high exactly when control bit 4 is set and bit 31 of either counter is set. It is a level and stays high with no further events.
- R10: A counter at 0xFFFFFFFF wraps to zero on its next event. Its bit 31 is then clear, so it no longer holds `irq` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 count register |
| wr_data | input | 64 | Write data (the control word uses bits 31:0) |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Read target: 0 control word, 1 count register |
| rd_data | output | 64 | Registered read data, valid the cycle after `rd_en` |
| events | input | 16 | Event pulse lines, one per event source |
| priv_exl | input | 1 | Core is at exception level |
| priv_lvl | input | 2 | Core privilege level: 0 kernel, 1 supervisor, 2 user |
| irq | output | 1 | Overflow interrupt level |

## Verification
Two functions of the block can land in the same cycle: a register access, and an increment caused by a qualifying event. The bench holds a selected event line high with the gate open while it issues a count write. It expects the written value back exactly, with no extra count. It also issues a count read in an incrementing cycle and expects the value from before the increment, then reads again to see the increment land. A control write issued while events are counting is checked in the same way: the old control word must still count in the write cycle, and counting must stop from the next cycle.

// File: rtl/dec_pkg.sv
package dec_pkg;
  // register port targets
  localparam logic SEL_CTRL  = 1'b0;
  localparam logic SEL_COUNT = 1'b1;

  // control word layout (decoded by neighbours, so positions are fixed)
  localparam int CTL_W      = 32;
  localparam int MODE_EXL   = 0;
  localparam int MODE_KERN  = 1;
  localparam int MODE_SUP   = 2;
  localparam int MODE_USER  = 3;
  localparam int MODE_N     = 4;
  localparam int IE_BIT     = 4;
  localparam int EVSEL_BASE = 5;
  localparam int NUM_CNT    = 2;

  // privilege level encoding
  localparam logic [1:0] LVL_KERN = 2'd0;
  localparam logic [1:0] LVL_SUP  = 2'd1;
  localparam logic [1:0] LVL_USER = 2'd2;
endpackage

// File: rtl/dec_ctrl_reg.sv
module dec_ctrl_reg
  import dec_pkg::*;
#(
  parameter int USED_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CTL_W-1:0] ctl_nxt
);
  logic [USED_W-1:0] bits_q;
  logic [USED_W-1:0] bits_d;

  always_comb begin
    bits_d = bits_q;
    if (we) bits_d = wdata[USED_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else     bits_q <= bits_d;
  end

  assign ctl_q   = CTL_W'(bits_q);
  assign ctl_nxt = CTL_W'(bits_d);
endmodule

// File: rtl/dec_mode_gate.sv
module dec_mode_gate
  import dec_pkg::*;
(
  input  logic              priv_exl,
  input  logic [1:0]        priv_lvl,
  input  logic [MODE_N-1:0] mode_en,
  output logic              gate_open
);
  logic [MODE_N-1:0] active;

  always_comb begin
    active = '0;
    if (priv_exl) begin
      active[MODE_EXL] = 1'b1;
    end else begin
      case (priv_lvl)
        LVL_KERN: active[MODE_KERN] = 1'b1;
        LVL_SUP:  active[MODE_SUP]  = 1'b1;
        LVL_USER: active[MODE_USER] = 1'b1;
        default:  active = '0;
      endcase
    end
  end

  assign gate_open = |(active & mode_en);
endmodule

// File: rtl/dec_counter.sv
module dec_counter #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 16,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   evt_sel,
  input  logic [NUM_EVT-1:0] events,
  input  logic               gate_open,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   cnt_nxt
);
  logic hit;

  assign hit = gate_open & events[evt_sel];

  // a load wins over a hit in the same cycle; no saturation
  always_comb begin
    cnt_nxt = cnt_q;
    if (load)     cnt_nxt = load_val;
    else if (hit) cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/dual_event_counter.sv
module dual_event_counter
  import dec_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [2*CNT_W-1:0]   wr_data,
  input  logic                 rd_en,
  input  logic                 rd_sel,
  output logic [2*CNT_W-1:0]   rd_data,
  input  logic [NUM_EVT-1:0]   events,
  input  logic                 priv_exl,
  input  logic [1:0]           priv_lvl,
  output logic                 irq
);
  localparam int SEL_W  = $clog2(NUM_EVT);
  localparam int USED_W = EVSEL_BASE + NUM_CNT * SEL_W;
  localparam int REG_W  = NUM_CNT * CNT_W;
  localparam int OVF    = CNT_W - 1;

  logic [CTL_W-1:0]               ctl_q;
  logic [CTL_W-1:0]               ctl_nxt;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_nxt;
  logic [NUM_CNT-1:0]             ovf_nxt;
  logic                           gate_open;
  logic                           ctl_we;
  logic                           cnt_we;

  assign ctl_we = wr_en & (wr_sel == SEL_CTRL);
  assign cnt_we = wr_en & (wr_sel == SEL_COUNT);

  dec_ctrl_reg #(.USED_W(USED_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .we      (ctl_we),
    .wdata   (wr_data[CTL_W-1:0]),
    .ctl_q   (ctl_q),
    .ctl_nxt (ctl_nxt)
  );

  dec_mode_gate u_gate (
    .priv_exl  (priv_exl),
    .priv_lvl  (priv_lvl),
    .mode_en   (ctl_q[MODE_N-1:0]),
    .gate_open (gate_open)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    dec_counter #(
      .CNT_W   (CNT_W),
      .NUM_EVT (NUM_EVT),
      .SEL_W   (SEL_W)
    ) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .evt_sel   (ctl_q[EVSEL_BASE + g*SEL_W +: SEL_W]),
      .events    (events),
      .gate_open (gate_open),
      .load      (cnt_we),
      .load_val  (wr_data[g*CNT_W +: CNT_W]),
      .cnt_q     (cnt_q[g]),
      .cnt_nxt   (cnt_nxt[g])
    );
    assign ovf_nxt[g] = cnt_nxt[g][OVF];
  end

  // interrupt level registered from next state so it lines up with the counters
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ctl_nxt[IE_BIT] & (|ovf_nxt);
  end

  // registered read port; samples state before this cycle's update
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_sel == SEL_COUNT) rd_data <= cnt_q;
      else                     rd_data <= REG_W'(ctl_q);
    end
  end
endmodule

// File: rtl/dec_checker.sv
module dec_checker #(
  parameter int CNT_W = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic                   wr_sel,
  input logic [2*CNT_W-1:0]     wr_data,
  input logic                   rd_en,
  input logic                   rd_sel,
  input logic [2*CNT_W-1:0]     rd_data,
  input logic                   irq,
  input logic [31:0]            ctl_q,
  input logic [1:0][CNT_W-1:0]  cnt_q
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ctl_q == '0 && cnt_q == '0 && !irq && rd_data == '0));

  assert_ctl_read_upper_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_sel) |=> (rd_data[2*CNT_W-1:13] == '0));

  assert_load_both_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> (cnt_q == $past(wr_data)));

  assert_step_lo_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_sel) |=> (CNT_W'(cnt_q[0] - $past(cnt_q[0])) <= CNT_W'(1)));

  assert_step_hi_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_sel) |=> (CNT_W'(cnt_q[1] - $past(cnt_q[1])) <= CNT_W'(1)));

  assert_stopped_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[3:0] == 4'd0 && !(wr_en && wr_sel)) |=> $stable(cnt_q));

  assert_read_old_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel) |=> (rd_data == $past(cnt_q)));

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (ctl_q[4] && (cnt_q[0][CNT_W-1] || cnt_q[1][CNT_W-1])));
endmodule

bind dual_event_counter dec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_sel  (rd_sel),
  .rd_data (rd_data),
  .irq     (irq),
  .ctl_q   (ctl_q),
  .cnt_q   (cnt_q)
);

// File: tb/tb_dual_event_counter.sv
module tb_dual_event_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [63:0] rd_data;
  logic [15:0] events = '0;
  logic        priv_exl = 1'b0;
  logic [1:0]  priv_lvl = 2'd0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_event_counter dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .events(events),
    .priv_exl(priv_exl), .priv_lvl(priv_lvl), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [63:0] v);
    rd_sel = sel; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    chk(irq == 1'b0, "R1 irq", {63'd0, irq}, 64'd0);
    chk(rd_data == '0, "R1 rd_data", rd_data, 64'd0);
    rd(1'b0, v); chk(v == '0, "R1 ctl", v, 64'd0);
    rd(1'b1, v); chk(v == '0, "R1 count", v, 64'd0);
  endtask

  task automatic t_ctl_rw();
    logic [63:0] v;
    wr(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(1'b0, v); chk(v == 64'h1FFF, "R2 ctl mask", v, 64'h1FFF);
    wr(1'b0, 64'h0000_0000_0000_0A5C);
    rd(1'b0, v); chk(v == 64'h0A5C, "R2 ctl value", v, 64'h0A5C);
    wr(1'b0, 64'd0);
  endtask

  task automatic t_cnt_rw();
    logic [63:0] v;
    wr(1'b1, 64'hAAAA_5555_1234_5678);
    rd(1'b1, v); chk(v == 64'hAAAA_5555_1234_5678, "R3 count load", v, 64'hAAAA_5555_1234_5678);
  endtask

  task automatic t_select();
    logic [63:0] v;
    priv_exl = 1'b0; priv_lvl = 2'd0;
    wr(1'b0, 64'h0E62);              // sel1=3 sel2=7 kernel
    wr(1'b1, 64'd0);
    events = 16'h0009; step(5);
    events = 16'h0080; step(3);
    events = 16'h0000;
    rd(1'b1, v); chk(v == 64'h0000_0003_0000_0005, "R4 event select", v, 64'h0000_0003_0000_0005);
  endtask

  task automatic t_gate();
    logic [63:0] v;
    wr(1'b0, 64'h8);                 // user only, both select line 0
    wr(1'b1, 64'd0);
    events = 16'h0001;
    priv_exl = 1'b0; priv_lvl = 2'd0; step(2);
    priv_lvl = 2'd1; step(2);
    priv_exl = 1'b1; priv_lvl = 2'd2; step(2);
    priv_exl = 1'b0; step(3);
    events = 16'h0;
    rd(1'b1, v); chk(v == 64'h0000_0003_0000_0003, "R5 user gate", v, 64'h0000_0003_0000_0003);
    wr(1'b0, 64'h1);                 // exception level only
    events = 16'h0001; priv_exl = 1'b1; step(2);
    events = 16'h0; priv_exl = 1'b0;
    rd(1'b1, v); chk(v == 64'h0000_0005_0000_0005, "R5 exl gate", v, 64'h0000_0005_0000_0005);
    wr(1'b0, 64'hF);
    priv_lvl = 2'd3; events = 16'h0001; step(2);
    events = 16'h0;
    rd(1'b1, v); chk(v == 64'h0000_0005_0000_0005, "R5 level 3 no count", v, 64'h0000_0005_0000_0005);
  endtask

  task automatic t_stop();
    logic [63:0] v;
    priv_exl = 1'b0; priv_lvl = 2'd2;
    wr(1'b0, 64'h8);
    wr(1'b1, 64'h0000_0100_0000_0200);
    events = 16'h0001; step(2);
    wr(1'b0, 64'd0);                 // old word still counts in this cycle
    step(4);
    events = 16'h0;
    rd(1'b1, v); chk(v == 64'h0000_0103_0000_0203, "R6 stop holds", v, 64'h0000_0103_0000_0203);
  endtask

  task automatic t_load_wins();
    logic [63:0] v;
    wr(1'b0, 64'h8);
    events = 16'h0001; step(1);
    wr(1'b1, 64'h0000_0010_0000_0020);
    events = 16'h0;
    rd(1'b1, v); chk(v == 64'h0000_0010_0000_0020, "R7 write over increment", v, 64'h0000_0010_0000_0020);
  endtask

  task automatic t_read_old();
    logic [63:0] v;
    wr(1'b1, 64'h0000_0050_0000_0060);
    events = 16'h0001;
    rd(1'b1, v);
    events = 16'h0;
    chk(v == 64'h0000_0050_0000_0060, "R8 read before increment", v, 64'h0000_0050_0000_0060);
    rd(1'b1, v); chk(v == 64'h0000_0051_0000_0061, "R8 increment landed", v, 64'h0000_0051_0000_0061);
  endtask

  task automatic t_irq();
    wr(1'b0, 64'h18);                // user + interrupt enable
    wr(1'b1, 64'h0000_0010_7FFF_FFFE);
    events = 16'h0001; step(1); events = 16'h0;
    chk(irq == 1'b0, "R9 below overflow", {63'd0, irq}, 64'd0);
    events = 16'h0001; step(1); events = 16'h0;
    chk(irq == 1'b1, "R9 overflow raises", {63'd0, irq}, 64'd1);
    step(3);
    chk(irq == 1'b1, "R9 level held", {63'd0, irq}, 64'd1);
    wr(1'b0, 64'h8);
    chk(irq == 1'b0, "R9 enable cleared", {63'd0, irq}, 64'd0);
    wr(1'b0, 64'h18);
    chk(irq == 1'b1, "R9 enable restored", {63'd0, irq}, 64'd1);
    wr(1'b1, 64'h0000_0010_0000_0010);
    chk(irq == 1'b0, "R9 reload clears", {63'd0, irq}, 64'd0);
    wr(1'b1, 64'h8000_0000_0000_0010);
    chk(irq == 1'b1, "R9 counter 2 alone", {63'd0, irq}, 64'd1);
  endtask

  task automatic t_wrap();
    logic [63:0] v;
    wr(1'b1, 64'h0000_0010_FFFF_FFFF);
    chk(irq == 1'b1, "R10 before wrap", {63'd0, irq}, 64'd1);
    events = 16'h0001; step(1); events = 16'h0;
    chk(irq == 1'b0, "R10 wrap drops irq", {63'd0, irq}, 64'd0);
    rd(1'b1, v); chk(v == 64'h0000_0011_0000_0000, "R10 wrap value", v, 64'h0000_0011_0000_0000);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_ctl_rw();
    t_cnt_rw();
    t_select();
    t_gate();
    t_stop();
    t_load_wins();
    t_read_old();
    t_irq();
    t_wrap();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end
endmodule